// File: doc/BRIEF.md
# I/O-Bus Real-Time Clock Counter

This block is a real-time clock peripheral that sits on a minicomputer-style I/O bus and holds no memory. It keeps a 16-bit count. Each time an external periodic strobe arrives while the clock is running, the count grows by a programmable step. Whenever an update moves the upper byte of the count to a new value, the block latches an interrupt request. Because it compares the upper byte before and after each update, a large step never skips an overflow the way a check for one exact terminal value could.

The CPU controls the clock with single-cycle bus commands. Each command is a 2-bit instruction kind plus a 6-bit function code. Control pulses stop or start the clock. Input commands read back the count and raise the skip response. Every other pair is refused with a bad-function flag. Responses come out of registers and are valid in the cycle after the command. The bus is a strobe interface with no back-pressure: the block accepts a command in every cycle in which `io_valid_i` is high and never stalls the bus. The interrupt enable is loaded through its own write strobe. The request is acknowledged by a pulse.

Top module: `iobus_rtc`

## Requirements
- R1: While the clock runs, each cycle with `tick_i` high adds the step to the count modulo 2^16.
- R2: A step input of zero advances the count by one.
- R3: The pending request is set on a tick whose update leaves bits 15:8 of the count different from their value before the update. With a step of 1, the first request comes on the 256th tick.
- R4: While the clock is stopped, ticks change neither the count nor the pending request.
- R5: A command of kind 0 (control pulse) with function 6'o10 stops the clock and clears the pending request.
- R6: A command of kind 0 with function 6'o00 starts the clock and clears the pending request. When the clock is already running, this command leaves the count untouched.
- R7: A command of kind 1 (input) with function 6'o10 or 6'o00 drives the count on `rd_data_o` with `skip_o` high in the next cycle. `skip_o` is low in every other cycle.
- R8: A read issued in the same cycle as a counting tick returns the count from before that tick.
- R9: Every other command pulses `badfn_o` in the next cycle without `skip_o`, and changes neither the count, the run state nor the pending request. Kind 2 (output) and kind 3 (sense) are always refused.
- R10: `irq_o` equals the pending request ANDed with the enable bit, which `ien_we_i` loads from `ien_d_i`. `irq_ack_i` clears the request. A set event in the same cycle as a clear takes precedence.
- R11: Reset gives count 0, clock running, enable 0 and no pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Periodic advance strobe |
| step_i | input | 16 | Amount added per tick (0 means 1) |
| io_valid_i | input | 1 | Bus command present this cycle |
| io_kind_i | input | 2 | Instruction kind: 0 pulse, 1 input, 2 output, 3 sense |
| io_func_i | input | 6 | Function code |
| rd_data_o | output | 16 | Count returned by the last read |
| skip_o | output | 1 | Skip response, one cycle after a read |
| badfn_o | output | 1 | Unimplemented command, one cycle after it |
| ien_we_i | input | 1 | Load the interrupt enable |
| ien_d_i | input | 1 | New interrupt enable value |
| irq_ack_i | input | 1 | Acknowledge and clear the request |
| irq_pend_o | output | 1 | Pending request |
| irq_o | output | 1 | Request gated by the enable |

## Verification
The assertions watch several rules on every cycle. A count that receives no qualified tick holds its value. A zero step adds exactly one. A set event always leaves a request pending, and a clear without a set always removes it. A stop command always leaves the clock halted. A valid read always produces a skip, and skip and bad-function never appear together. Only the bench scenarios can show the byte-boundary timing: the 256th unit tick, wrap of large steps, a read that coincides with a tick, a start command that leaves a running count alone, refused commands that leave state intact, and the enable gating across a reset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FN_W = 6;

  typedef enum logic [1:0] {
    IO_PULSE = 2'b00,
    IO_INPUT = 2'b01,
    IO_OUTPUT = 2'b10,
    IO_SENSE = 2'b11
  } io_kind_e;

  localparam logic [FN_W-1:0] FN_RUN  = 6'o00;
  localparam logic [FN_W-1:0] FN_HALT = 6'o10;

  typedef struct packed {
    logic halt;
    logic run;
    logic rd;
    logic bad;
  } cmd_dec_t;
endpackage

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_pkg::*;
(
  input  logic            valid_i,
  input  logic [1:0]      kind_i,
  input  logic [FN_W-1:0] func_i,
  output cmd_dec_t        dec_o
);
  always_comb begin
    dec_o = '0;
    if (valid_i) begin
      case (kind_i)
        IO_PULSE: begin
          if (func_i == FN_HALT)     dec_o.halt = 1'b1;
          else if (func_i == FN_RUN) dec_o.run  = 1'b1;
          else                       dec_o.bad  = 1'b1;
        end
        IO_INPUT: begin
          if (func_i == FN_HALT || func_i == FN_RUN) dec_o.rd = 1'b1;
          else                                       dec_o.bad = 1'b1;
        end
        default: dec_o.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hi_chg_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q, eff_step, next_cnt;

  assign eff_step = (step_i == '0) ? ONE : step_i;
  assign next_cnt = count_q + eff_step;
  assign hi_chg_o = adv_i && (next_cnt[CNT_W-1:LOW_W] != count_q[CNT_W-1:LOW_W]);
  assign count_o  = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (adv_i) count_q <= next_cnt;
  end

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(count_o));

  // R2
  zero_step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && step_i == '0) |=> count_o == $past(count_o) + ONE);
endmodule

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  input  logic ien_we_i,
  input  logic ien_d_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q, ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      pend_q <= set_i | (pend_q & ~(clr_i | ack_i));
      if (ien_we_i) ien_q <= ien_d_i;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & ien_q;

  // R3
  set_leaves_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);

  // R10
  clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i || ack_i) && !set_i) |=> !pend_o);
endmodule

// File: rtl/iobus_rtc.sv
module iobus_rtc
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic             io_valid_i,
  input  logic [1:0]       io_kind_i,
  input  logic [FN_W-1:0]  io_func_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             skip_o,
  output logic             badfn_o,
  input  logic             ien_we_i,
  input  logic             ien_d_i,
  input  logic             irq_ack_i,
  output logic             irq_pend_o,
  output logic             irq_o
);
  cmd_dec_t         dec;
  logic             run_q, adv, hi_chg;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] rd_q;
  logic             skip_q, bad_q;

  rtc_cmd_decode u_dec (
    .valid_i (io_valid_i),
    .kind_i  (io_kind_i),
    .func_i  (io_func_i),
    .dec_o   (dec)
  );

  assign adv = tick_i & run_q;

  rtc_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv),
    .step_i   (step_i),
    .count_o  (count),
    .hi_chg_o (hi_chg)
  );

  rtc_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (hi_chg),
    .clr_i    (dec.halt | dec.run),
    .ack_i    (irq_ack_i),
    .ien_we_i (ien_we_i),
    .ien_d_i  (ien_d_i),
    .pend_o   (irq_pend_o),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b1;
      rd_q   <= '0;
      skip_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      if (dec.halt)     run_q <= 1'b0;
      else if (dec.run) run_q <= 1'b1;
      if (dec.rd) rd_q <= count;
      skip_q <= dec.rd;
      bad_q  <= dec.bad;
    end
  end

  assign rd_data_o = rd_q;
  assign skip_o    = skip_q;
  assign badfn_o   = bad_q;

  // R5
  halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid_i && io_kind_i == IO_PULSE && io_func_i == FN_HALT) |=> !run_q);

  // R7
  read_skips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid_i && io_kind_i == IO_INPUT && (io_func_i == FN_HALT || io_func_i == FN_RUN))
      |=> skip_o);

  // R9
  skip_xor_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(skip_o && badfn_o));
endmodule

// File: tb/iobus_rtc_tb.sv
module iobus_rtc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [15:0] step_i = '0;
  logic        io_valid_i = 1'b0;
  logic [1:0]  io_kind_i = '0;
  logic [5:0]  io_func_i = '0;
  logic [15:0] rd_data_o;
  logic        skip_o, badfn_o;
  logic        ien_we_i = 1'b0, ien_d_i = 1'b0, irq_ack_i = 1'b0;
  logic        irq_pend_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  iobus_rtc u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .step_i(step_i),
    .io_valid_i(io_valid_i), .io_kind_i(io_kind_i), .io_func_i(io_func_i),
    .rd_data_o(rd_data_o), .skip_o(skip_o), .badfn_o(badfn_o),
    .ien_we_i(ien_we_i), .ien_d_i(ien_d_i), .irq_ack_i(irq_ack_i),
    .irq_pend_o(irq_pend_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick_i = 0; io_valid_i = 0; ien_we_i = 0; irq_ack_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick(input logic [15:0] s);
    tick_i = 1'b1; step_i = s;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] k, input logic [5:0] f);
    io_valid_i = 1'b1; io_kind_i = k; io_func_i = f;
    @(negedge clk);
    io_valid_i = 1'b0;
  endtask

  task automatic rd_count(output logic [15:0] v, output logic sk);
    do_cmd(2'd1, 6'o10);
    v = rd_data_o; sk = skip_o;
  endtask

  task automatic t_reset();
    logic [15:0] v; logic sk;
    do_reset();
    chk("R11 pend", irq_pend_o, 0);
    chk("R11 irq", irq_o, 0);
    chk("R7 skip idle", skip_o, 0);
    rd_count(v, sk);
    chk("R11 count", v, 0);
    do_tick(16'd1);
    rd_count(v, sk);
    chk("R11 running", v, 1);
  endtask

  task automatic t_wrap();
    logic [15:0] v; logic sk;
    do_reset();
    repeat (3) do_tick(16'h7000);
    rd_count(v, sk);
    chk("R1 wrap", v, 16'h5000);
  endtask

  task automatic t_zero_step();
    logic [15:0] v; logic sk;
    do_reset();
    repeat (2) do_tick(16'h0000);
    rd_count(v, sk);
    chk("R2 zero step", v, 2);
  endtask

  task automatic t_byte();
    logic [15:0] v; logic sk;
    do_reset();
    for (int i = 0; i < 255; i++) do_tick(16'd1);
    chk("R3 no req at 255", irq_pend_o, 0);
    do_tick(16'd1);
    chk("R3 req at 256", irq_pend_o, 1);
    do_cmd(2'd0, 6'o00);
    do_tick(16'h1234);
    chk("R3 big step req", irq_pend_o, 1);
    do_cmd(2'd0, 6'o00);
    do_tick(16'h0010);
    chk("R3 same hi no req", irq_pend_o, 0);
  endtask

  task automatic t_stopped();
    logic [15:0] v; logic sk;
    do_reset();
    do_cmd(2'd0, 6'o10);
    repeat (3) do_tick(16'h0100);
    chk("R4 no req stopped", irq_pend_o, 0);
    rd_count(v, sk);
    chk("R4 count held", v, 0);
  endtask

  task automatic t_halt();
    logic [15:0] v; logic sk;
    do_reset();
    do_tick(16'h0100);
    chk("R5 req before halt", irq_pend_o, 1);
    do_cmd(2'd0, 6'o10);
    chk("R5 req cleared", irq_pend_o, 0);
    do_tick(16'd1);
    rd_count(v, sk);
    chk("R5 halted count", v, 16'h0100);
  endtask

  task automatic t_start();
    logic [15:0] v; logic sk;
    do_reset();
    do_tick(16'd5);
    do_tick(16'h0100);
    chk("R6 req set", irq_pend_o, 1);
    do_cmd(2'd0, 6'o00);
    chk("R6 req cleared", irq_pend_o, 0);
    rd_count(v, sk);
    chk("R6 count kept", v, 16'h0105);
    do_cmd(2'd0, 6'o10);
    do_tick(16'd1);
    do_cmd(2'd0, 6'o00);
    do_tick(16'd1);
    rd_count(v, sk);
    chk("R6 resumes", v, 16'h0106);
  endtask

  task automatic t_read();
    logic [15:0] v; logic sk;
    do_reset();
    do_tick(16'h0ABC);
    do_cmd(2'd1, 6'o00);
    chk("R7 data f00", rd_data_o, 16'h0ABC);
    chk("R7 skip f00", skip_o, 1);
    rd_count(v, sk);
    chk("R7 skip f10", sk, 1);
    @(negedge clk);
    chk("R7 skip drops", skip_o, 0);
  endtask

  task automatic t_read_tick();
    logic [15:0] v; logic sk;
    do_reset();
    do_tick(16'd7);
    tick_i = 1'b1; step_i = 16'd3;
    io_valid_i = 1'b1; io_kind_i = 2'd1; io_func_i = 6'o10;
    @(negedge clk);
    tick_i = 1'b0; io_valid_i = 1'b0;
    chk("R8 pre-tick value", rd_data_o, 16'd7);
    rd_count(v, sk);
    chk("R8 tick applied", v, 16'd10);
  endtask

  task automatic t_bad();
    logic [15:0] v; logic sk;
    do_reset();
    do_tick(16'h0100);
    do_cmd(2'd0, 6'o01);
    chk("R9 pulse bad", badfn_o, 1);
    chk("R9 no skip", skip_o, 0);
    chk("R9 req kept", irq_pend_o, 1);
    do_cmd(2'd2, 6'o00);
    chk("R9 output bad", badfn_o, 1);
    do_cmd(2'd3, 6'o10);
    chk("R9 sense bad", badfn_o, 1);
    do_cmd(2'd1, 6'o03);
    chk("R9 input bad", badfn_o, 1);
    chk("R9 input no skip", skip_o, 0);
    do_tick(16'd1);
    rd_count(v, sk);
    chk("R9 state kept", v, 16'h0101);
    chk("R9 bad drops", badfn_o, 0);
  endtask

  task automatic t_ien();
    do_reset();
    do_tick(16'h0100);
    chk("R10 gated off", irq_o, 0);
    ien_we_i = 1; ien_d_i = 1;
    @(negedge clk);
    ien_we_i = 0;
    chk("R10 gated on", irq_o, 1);
    irq_ack_i = 1;
    @(negedge clk);
    irq_ack_i = 0;
    chk("R10 ack pend", irq_pend_o, 0);
    chk("R10 ack irq", irq_o, 0);
    irq_ack_i = 1;
    do_tick(16'h0100);
    irq_ack_i = 0;
    chk("R10 set beats ack", irq_pend_o, 1);
    do_reset();
    do_tick(16'h0100);
    chk("R11 ien cleared", irq_o, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_wrap();
    t_zero_step();
    t_byte();
    t_stopped();
    t_halt();
    t_start();
    t_read();
    t_read_tick();
    t_bad();
    t_ien();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule